// File: doc/BRIEF.md
# Triggered ADC Sample FIFO

This block sits between an analog-to-digital converter and a register-mapped host. It picks one line of a 64-line event bus as the conversion-start source, resynchronises it, and detects either its rising or its falling edge. The host may also start a conversion by hand. Each accepted trigger sends one single-cycle start pulse to the converter. The converter is modelled as a start/done/data handshake. The 12-bit result that returns with the done strobe is stored in a four-entry FIFO.

The host controls the block through a command field: off, run, or flush. It reads samples oldest first and watches five status flags. Two of these flags, overflow and underflow, are sticky error flags. While one is set, the pointer it guards is frozen until the host issues a flush. The host can also push dummy samples for bring-up. Dummy samples obey the same acceptance rules as converter results.

Top module: `adc_trig_fifo`

## Requirements
- R1: After reset the status reads empty=1 and almost-full, full, overflow and underflow all 0. `adc_start` is 0 and `rd_data` is 0. The readback shows command 00 (off), source 0x3F and polarity 0.
- R2: The FIFO holds 4 samples of 12 bits and returns them oldest first. A sample appears on `rd_data` one cycle after `rd_en` is sampled high.
- R3: `st_empty` is 1 only at 0 entries. `st_afull` is 1 only at exactly 3 entries. `st_full` is 1 only at 4 entries, and `st_afull` is then 0.
- R4: Pushing while full sets the sticky `st_overflow` flag. While the flag is set, no sample is stored and the stored count does not grow.
- R5: Reading while empty leaves `rd_data` at the last sample read and sets the sticky `st_underflow` flag. While the flag is set, reads do not advance and `rd_data` holds its value, even after new samples arrive.
- R6: A control write (`ctl_wr`) loads the command, source and polarity, and they read back unchanged on the next cycle. The command codes are 00 = off, 01 = run, 11 = flush, and 10 acts as off. A write with command 11 empties the FIFO and clears both sticky flags.
- R7: A source value N selects `ev_bus[N]`. The codes 0x2C, 0x2D, 0x39 through 0x3C, 0x3E and 0x3F select no event and never trigger.
- R8: Polarity 0 triggers on a rising edge of the selected line and polarity 1 on a falling edge. After a two-flop synchroniser, `adc_start` goes high in the cycle after the third rising clock edge that samples the new level. The opposite edge does nothing.
- R9: A `man_trig` strobe sampled high produces `adc_start` high for exactly one cycle, starting right after that clock edge.
- R10: A `dmy_wr` strobe pushes `dmy_data` under the same rules as a converter sample. If a converter sample and a dummy write arrive in the same cycle, the converter sample is stored and the dummy is dropped.
- R11: Unless the command is 01, triggers raise no start, converter results are not stored and dummy writes are ignored. Leaving run mode cancels a conversion in flight.
- R12: After a start, further triggers are dropped until `adc_done` arrives. An `adc_done` with no conversion in flight stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_cmd | input | 2 | Command to write |
| ctl_src | input | 6 | Trigger source index to write |
| ctl_pol | input | 1 | Trigger polarity to write (0 rising, 1 falling) |
| cfg_cmd | output | 2 | Stored command readback |
| cfg_src | output | 6 | Stored source readback |
| cfg_pol | output | 1 | Stored polarity readback |
| man_trig | input | 1 | Manual trigger strobe |
| dmy_wr | input | 1 | Dummy sample write strobe |
| dmy_data | input | 12 | Dummy sample value |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 12 | Last sample read |
| st_empty | output | 1 | FIFO holds no sample |
| st_afull | output | 1 | FIFO holds exactly three samples |
| st_full | output | 1 | FIFO holds four samples |
| st_overflow | output | 1 | Sticky overflow flag |
| st_underflow | output | 1 | Sticky underflow flag |
| ev_bus | input | 64 | Asynchronous event lines |
| adc_start | output | 1 | Conversion start pulse |
| adc_done | input | 1 | Conversion finished strobe |
| adc_data | input | 12 | Conversion result |

## Verification
Each result has a fixed due cycle:

- Control readback, status flags and `rd_data` are due one clock edge after their strobe.
- A manual start is due one edge after `man_trig`.
- An event-driven start is due on the third edge after the event line changes: two synchroniser flops, then the start register.

The bench drives every input just after a falling clock edge. It samples on the falling edge that follows exactly the counted number of rising edges. For an event it checks that `adc_start` is still low after the first and second edges, high after the third and low again after the fourth. Cases that must not start are watched across several cycles instead of at one point.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        CMD_OFF   = 2'b00,
        CMD_RUN   = 2'b01,
        CMD_RSV   = 2'b10,
        CMD_FLUSH = 2'b11
    } cmd_e;

    // one bit per source code; 0 means the code selects no event
    localparam logic [63:0] EV_VALID_DEF = 64'h21FF_CFFF_FFFF_FFFF;

endpackage

// File: rtl/ev_trig_sel.sv
module ev_trig_sel #(
    parameter int SRC_W = 6,
    parameter int NEV   = 1 << SRC_W,
    parameter logic [NEV-1:0] EV_VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEV-1:0]   ev_bus,
    input  logic [SRC_W-1:0] src,
    input  logic             pol,
    output logic             ev_fire
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t r_d, r_q;
    logic  sel;

    always_comb begin
        sel    = EV_VALID[src] ? ev_bus[src] : 1'b0;
        r_d    = r_q;
        r_d.s1 = sel;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // polarity applied after synchronising so a polarity change alone makes no edge
    assign ev_fire = (r_q.s2 ^ pol) & ~(r_q.s3 ^ pol);

endmodule

// File: rtl/conv_ctl.sv
module conv_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic trig,
    input  logic done,
    output logic start,
    output logic take
);

    typedef struct packed {
        logic start;
        logic busy;
    } cv_t;

    cv_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        if (!en) begin
            c_d.busy = 1'b0;
        end else if (c_q.busy) begin
            if (done) c_d.busy = 1'b0;
        end else if (trig) begin
            c_d.start = 1'b1;
            c_d.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign start = c_q.start;
    assign take  = en & c_q.busy & done;

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R11
    off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !start);
    // R12
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy && !done |=> !start);

endmodule

// File: rtl/adc_fifo.sv
module adc_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          afull,
    output logic          full,
    output logic          ovf,
    output logic          udf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     ovf;
        logic                     udf;
        logic [DW-1:0]            rdat;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  is_full, is_empty, do_w, do_r;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d      = f_q;
        is_full  = (f_q.cnt == CW'(DEPTH));
        is_empty = (f_q.cnt == '0);
        do_w     = push && !f_q.ovf && !is_full;
        do_r     = pop && !f_q.udf && !is_empty;
        if (flush) begin
            f_d.wp  = '0;
            f_d.rp  = '0;
            f_d.cnt = '0;
            f_d.ovf = 1'b0;
            f_d.udf = 1'b0;
        end else begin
            if (push && is_full) f_d.ovf = 1'b1;
            if (pop && is_empty) f_d.udf = 1'b1;
            if (do_w) begin
                f_d.mem[f_q.wp] = push_data;
                f_d.wp          = nxt(f_q.wp);
            end
            if (do_r) begin
                f_d.rdat = f_q.mem[f_q.rp];
                f_d.rp   = nxt(f_q.rp);
            end
            unique case ({do_w, do_r})
                2'b10:   f_d.cnt = f_q.cnt + 1'b1;
                2'b01:   f_d.cnt = f_q.cnt - 1'b1;
                default: f_d.cnt = f_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rd_data = f_q.rdat;
    assign empty   = (f_q.cnt == '0);
    assign afull   = (f_q.cnt == CW'(DEPTH - 1));
    assign full    = (f_q.cnt == CW'(DEPTH));
    assign ovf     = f_q.ovf;
    assign udf     = f_q.udf;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH));
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.ovf && !flush |=> f_q.ovf);
    // R4
    no_grow_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.ovf && !flush |=> f_q.cnt <= $past(f_q.cnt));
    // R5
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.udf && !flush |=> f_q.udf && $stable(rd_data));
    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && !ovf && !udf);

endmodule

// File: rtl/adc_trig_fifo.sv
module adc_trig_fifo
    import adc_trig_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 4,
    parameter int SRC_W = 6,
    parameter logic [(1 << SRC_W)-1:0] EV_VALID = EV_VALID_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic [1:0]              ctl_cmd,
    input  logic [SRC_W-1:0]        ctl_src,
    input  logic                    ctl_pol,
    output logic [1:0]              cfg_cmd,
    output logic [SRC_W-1:0]        cfg_src,
    output logic                    cfg_pol,
    input  logic                    man_trig,
    input  logic                    dmy_wr,
    input  logic [DW-1:0]           dmy_data,
    input  logic                    rd_en,
    output logic [DW-1:0]           rd_data,
    output logic                    st_empty,
    output logic                    st_afull,
    output logic                    st_full,
    output logic                    st_overflow,
    output logic                    st_underflow,
    input  logic [(1 << SRC_W)-1:0] ev_bus,
    output logic                    adc_start,
    input  logic                    adc_done,
    input  logic [DW-1:0]           adc_data
);

    localparam int NEV = 1 << SRC_W;

    typedef struct packed {
        cmd_e             cmd;
        logic [SRC_W-1:0] src;
        logic             pol;
    } ctl_t;

    ctl_t          k_d, k_q;
    logic          en, flush, ev_fire, take, push;
    logic [DW-1:0] push_data;

    always_comb begin
        k_d = k_q;
        if (ctl_wr) begin
            k_d.cmd = cmd_e'(ctl_cmd);
            k_d.src = ctl_src;
            k_d.pol = ctl_pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q.cmd <= CMD_OFF;
            k_q.src <= '1;
            k_q.pol <= 1'b0;
        end else begin
            k_q <= k_d;
        end
    end

    assign en        = (k_q.cmd == CMD_RUN);
    assign flush     = ctl_wr && (cmd_e'(ctl_cmd) == CMD_FLUSH);
    assign push      = take | (dmy_wr & en);
    assign push_data = take ? adc_data : dmy_data;

    assign cfg_cmd = k_q.cmd;
    assign cfg_src = k_q.src;
    assign cfg_pol = k_q.pol;

    ev_trig_sel #(
        .SRC_W    (SRC_W),
        .NEV      (NEV),
        .EV_VALID (EV_VALID)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_bus  (ev_bus),
        .src     (k_q.src),
        .pol     (k_q.pol),
        .ev_fire (ev_fire)
    );

    conv_ctl u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .trig  (ev_fire | man_trig),
        .done  (adc_done),
        .start (adc_start),
        .take  (take)
    );

    adc_fifo #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (rd_en),
        .rd_data   (rd_data),
        .empty     (st_empty),
        .afull     (st_afull),
        .full      (st_full),
        .ovf       (st_overflow),
        .udf       (st_underflow)
    );

    // R11
    off_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !flush && !rd_en |=> $stable({st_empty, st_afull, st_full, st_overflow}));
    // R6
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> cfg_src == $past(ctl_src) && cfg_pol == $past(ctl_pol));

endmodule

// File: tb/sim_adc_trig_fifo.sv
module sim_adc_trig_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_cmd = '0;
    logic [5:0]  ctl_src = '0;
    logic        ctl_pol = 1'b0;
    logic [1:0]  cfg_cmd;
    logic [5:0]  cfg_src;
    logic        cfg_pol;
    logic        man_trig = 1'b0;
    logic        dmy_wr = 1'b0;
    logic [11:0] dmy_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic        st_empty, st_afull, st_full, st_overflow, st_underflow;
    logic [63:0] ev_bus = '0;
    logic        adc_start;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    adc_trig_fifo u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_cmd(ctl_cmd),
        .ctl_src(ctl_src), .ctl_pol(ctl_pol), .cfg_cmd(cfg_cmd),
        .cfg_src(cfg_src), .cfg_pol(cfg_pol), .man_trig(man_trig),
        .dmy_wr(dmy_wr), .dmy_data(dmy_data), .rd_en(rd_en), .rd_data(rd_data),
        .st_empty(st_empty), .st_afull(st_afull), .st_full(st_full),
        .st_overflow(st_overflow), .st_underflow(st_underflow), .ev_bus(ev_bus),
        .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // flags packed as {empty, afull, full, overflow, underflow}
    function automatic int flags();
        return {st_empty, st_afull, st_full, st_overflow, st_underflow};
    endfunction

    task automatic wr_ctl(input logic [1:0] c, input logic [5:0] s, input logic p);
        ctl_wr = 1'b1; ctl_cmd = c; ctl_src = s; ctl_pol = p;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic dummy(input logic [11:0] d);
        dmy_wr = 1'b1; dmy_data = d;
        step();
        dmy_wr = 1'b0;
    endtask

    task automatic rd(output logic [11:0] d);
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic finish_conv(input logic [11:0] d);
        adc_done = 1'b1; adc_data = d;
        step();
        adc_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "flags", flags(), 5'b10000);
        chk("R1", "adc_start", adc_start, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "cfg_cmd", cfg_cmd, 0);
        chk("R1", "cfg_src", cfg_src, 6'h3F);
        chk("R1", "cfg_pol", cfg_pol, 0);
    endtask

    task automatic t_order();
        logic [11:0] d;
        wr_ctl(2'b01, 6'h3F, 1'b0);
        chk("R6", "cfg_cmd run", cfg_cmd, 1);
        dummy(12'hA01); chk("R3", "flags 1 entry", flags(), 5'b00000);
        dummy(12'hB02); chk("R3", "flags 2 entries", flags(), 5'b00000);
        dummy(12'hC03); chk("R3", "afull at 3", flags(), 5'b01000);
        dummy(12'hD04); chk("R3", "full at 4", flags(), 5'b00100);
        rd(d); chk("R2", "read 1", d, 12'hA01);
        rd(d); chk("R2", "read 2", d, 12'hB02);
        rd(d); chk("R2", "read 3", d, 12'hC03);
        rd(d); chk("R2", "read 4", d, 12'hD04);
        chk("R3", "empty after reads", flags(), 5'b10000);
    endtask

    task automatic t_overflow();
        logic [11:0] d;
        for (int i = 0; i < 4; i++) dummy(12'h100 + 12'(i));
        dummy(12'hEEE);
        chk("R4", "overflow on 5th push", flags(), 5'b00110);
        rd(d); chk("R4", "oldest kept", d, 12'h100);
        chk("R4", "afull with overflow", flags(), 5'b01010);
        dummy(12'hFFF);
        chk("R4", "no store while overflow", flags(), 5'b01010);
        rd(d); chk("R4", "read 2", d, 12'h101);
        rd(d); chk("R4", "read 3", d, 12'h102);
        rd(d); chk("R4", "read 4", d, 12'h103);
        chk("R4", "empty, overflow sticky", flags(), 5'b10010);
        wr_ctl(2'b11, 6'h3F, 1'b0);
        chk("R6", "flush clears overflow", flags(), 5'b10000);
        chk("R6", "cfg_cmd flush", cfg_cmd, 3);
        wr_ctl(2'b01, 6'h3F, 1'b0);
    endtask

    task automatic t_underflow();
        logic [11:0] d;
        dummy(12'h321);
        rd(d); chk("R5", "read stored", d, 12'h321);
        rd(d); chk("R5", "empty read returns last", d, 12'h321);
        chk("R5", "underflow set", flags(), 5'b10001);
        dummy(12'h654);
        rd(d); chk("R5", "read frozen", d, 12'h321);
        chk("R5", "underflow sticky, entry kept", flags(), 5'b00001);
        wr_ctl(2'b11, 6'h3F, 1'b0);
        chk("R6", "flush clears underflow", flags(), 5'b10000);
        wr_ctl(2'b01, 6'h3F, 1'b0);
        dummy(12'h987);
        rd(d); chk("R5", "read after flush", d, 12'h987);
    endtask

    task automatic t_manual();
        logic [11:0] d;
        man_trig = 1'b1;
        step(); chk("R9", "start after strobe", adc_start, 1);
        step(); chk("R12", "retrigger dropped while busy", adc_start, 0);
        man_trig = 1'b0;
        step(); chk("R9", "no extra start", adc_start, 0);
        finish_conv(12'h5A5);
        chk("R12", "sample stored", st_empty, 0);
        rd(d); chk("R2", "converter sample", d, 12'h5A5);
        finish_conv(12'h0F0);
        chk("R12", "stray done stores nothing", st_empty, 1);
    endtask

    task automatic watch_start(input int n, input string req, input string what, input int exp);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (adc_start) seen++;
        end
        chk(req, what, seen, exp);
    endtask

    task automatic ev_expect(input int bit_idx, input logic lvl, input string req);
        ev_bus[bit_idx] = lvl;
        step(); chk(req, "no start edge 1", adc_start, 0);
        step(); chk(req, "no start edge 2", adc_start, 0);
        step(); chk(req, "start on edge 3", adc_start, 1);
        step(); chk(req, "start one cycle", adc_start, 0);
    endtask

    task automatic t_event();
        logic [11:0] d;
        ev_bus = '0;
        wr_ctl(2'b01, 6'd5, 1'b0);
        chk("R7", "cfg_src", cfg_src, 5);
        repeat (3) step();
        ev_expect(5, 1'b1, "R8");
        finish_conv(12'h123);
        rd(d); chk("R8", "rising-edge sample", d, 12'h123);
        wr_ctl(2'b01, 6'd5, 1'b1);
        chk("R6", "cfg_pol", cfg_pol, 1);
        repeat (3) step();
        ev_expect(5, 1'b0, "R8");
        finish_conv(12'h456);
        ev_bus[5] = 1'b1;
        watch_start(6, "R8", "rising ignored with falling polarity", 0);
        ev_bus = '0;
        wr_ctl(2'b01, 6'h2C, 1'b0);
        chk("R7", "cfg_src unlisted readback", cfg_src, 6'h2C);
        repeat (3) step();
        ev_bus[44] = 1'b1;
        watch_start(6, "R7", "code 0x2C never fires", 0);
        ev_bus = '0;
        wr_ctl(2'b01, 6'h3F, 1'b0);
        repeat (3) step();
        ev_bus[63] = 1'b1;
        watch_start(6, "R7", "code 0x3F never fires", 0);
        ev_bus = '0;
        wr_ctl(2'b01, 6'h3D, 1'b0);
        repeat (3) step();
        ev_expect(61, 1'b1, "R7");
        finish_conv(12'h789);
        ev_bus = '0;
        wr_ctl(2'b11, 6'h3F, 1'b0);
        wr_ctl(2'b01, 6'h3F, 1'b0);
    endtask

    task automatic t_disable();
        wr_ctl(2'b00, 6'h3F, 1'b0);
        chk("R6", "cfg_cmd off", cfg_cmd, 0);
        man_trig = 1'b1;
        watch_start(3, "R11", "no start when off", 0);
        man_trig = 1'b0;
        dummy(12'h111);
        chk("R11", "dummy ignored when off", st_empty, 1);
        wr_ctl(2'b10, 6'h3F, 1'b0);
        chk("R6", "cfg_cmd 10 readback", cfg_cmd, 2);
        man_trig = 1'b1;
        watch_start(3, "R6", "code 10 acts as off", 0);
        man_trig = 1'b0;
        dummy(12'h222);
        chk("R11", "dummy ignored with code 10", st_empty, 1);
        wr_ctl(2'b01, 6'h3F, 1'b0);
        man_trig = 1'b1; step(); man_trig = 1'b0;
        wr_ctl(2'b00, 6'h3F, 1'b0);
        finish_conv(12'h333);
        wr_ctl(2'b01, 6'h3F, 1'b0);
        finish_conv(12'h444);
        chk("R11", "conversion cancelled by off", st_empty, 1);
    endtask

    task automatic t_collide();
        logic [11:0] d;
        man_trig = 1'b1; step(); man_trig = 1'b0;
        adc_done = 1'b1; adc_data = 12'h777;
        dmy_wr = 1'b1; dmy_data = 12'h888;
        step();
        adc_done = 1'b0; dmy_wr = 1'b0;
        rd(d); chk("R10", "converter wins same cycle", d, 12'h777);
        chk("R10", "dummy dropped", st_empty, 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_order();
        t_overflow();
        t_underflow();
        t_manual();
        t_event();
        t_disable();
        t_collide();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule